// File: doc/BRIEF.md
# Three-Counter Register Machine Executor

This block is a sequential engine that runs a small counter-machine program. The program sits in an internal instruction table that a host fills through a write port. The engine owns three counters of a parameterised width. The host writes the starting counter values, pulses `start`, and waits for `done` or for an error flag. It then reads the counters back; the result of a computation is taken from counter 0.

Each table entry packs a two-bit operation in its low bits and a jump target state in the bits above them. The word value is therefore four times the target plus the operation. Operations 0, 1 and 2 are fused test-and-decrement branches on counter 0, 1 and 2. Operation 3 increments all three counters at once. State 0 means halt, and execution always begins in state 1. The engine retires one instruction per clock cycle. Stepping past the representable counter range, or jumping to a state outside the table, stops the machine with a sticky error.

Top module: `tcm_engine`

## Requirements
- R1: A table word holds the operation in bits [1:0] and the jump target state j in bits [WORD_W-1:2]; the entry for state s is the word written at table address s.
- R2: For operations 0, 1 and 2, a nonzero selected counter (counter 0, 1 or 2 respectively) is decremented by one, the other two counters keep their values, and the next state is j.
- R3: For operations 0, 1 and 2, a selected counter that is already zero stays at zero, all counters keep their values, and the next state is j+1.
- R4: Operation 3 increments all three counters by one in the same cycle, and the next state is j.
- R5: A `start` pulse while idle raises `busy` at the next clock edge, clears `done` and begins in state 1. Exactly one instruction is executed per clock cycle. On entering state 0 the engine drops `busy`, raises `done`, and the counters then hold still.
- R6: While `busy` is high, `start`, counter loads (`ld_en`) and table writes (`prog_we`) are ignored.
- R7: An operation 3 issued while any counter holds its maximum value (2^CNT_W-1) changes no counter, sets the sticky `err_ovf` and stops the engine.
- R8: A next state (j or j+1) at or above DEPTH changes no counter, sets the sticky `err_range` and stops the engine.
- R9: While either error flag is set, `start` is ignored; the flags persist until reset.
- R10: A synchronous reset clears all counters, `busy`, `done` and both error flags, but leaves the instruction table unchanged.
- R11: A counter load while idle writes `ld_val` into the counter numbered by `ld_sel` (0, 1 or 2); `ld_sel` = 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| prog_we | input | 1 | Table write enable |
| prog_addr | input | ST_W | Table write address (state number) |
| prog_data | input | WORD_W | Table word: target in the upper bits, operation in bits [1:0] |
| ld_en | input | 1 | Counter load enable |
| ld_sel | input | 2 | Counter number for a load |
| ld_val | input | CNT_W | Counter load value |
| start | input | 1 | Begin execution at state 1 |
| busy | output | 1 | Engine is executing |
| done | output | 1 | Halt state reached |
| err_ovf | output | 1 | Sticky counter overflow error |
| err_range | output | 1 | Sticky jump-out-of-table error |
| cnt0 | output | CNT_W | Counter 0 (result) |
| cnt1 | output | CNT_W | Counter 1 |
| cnt2 | output | CNT_W | Counter 2 |

## Verification
The embedded properties assume that the host keeps `rst` high for at least one edge before the first run. They also assume that the host does not expect a write to an unused table address to have any effect. Every other input sequence is legal, since the engine itself ignores loads, writes and starts that come while it is running or in error. The stimulus writes every program entry before it starts the engine. It pulses `start` for exactly one cycle, except where it deliberately pulses it again, or loads counters, in the middle of a run to exercise the ignore rules. The bench compares counters, flags and the executed-instruction count against a step-by-step arithmetic model of the instruction semantics. It sweeps starting counter values across small ranges and right up to the counter limit.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

   typedef enum logic [1:0] {
      OP_TST0   = 2'd0,
      OP_TST1   = 2'd1,
      OP_TST2   = 2'd2,
      OP_BUMPALL = 2'd3
   } tcm_op_e;

   localparam int NUM_CNT = 3;

endpackage

// File: rtl/tcm_prog_mem.sv
module tcm_prog_mem #(
   parameter int DEPTH  = 12,
   parameter int ST_W   = 4,
   parameter int WORD_W = 6
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ST_W-1:0]   wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [ST_W-1:0]   rd_addr,
   output logic [WORD_W-1:0] rd_data
);

   // Table storage has no reset: contents survive a reset of the engine.
   logic [WORD_W-1:0] mem [DEPTH];

   localparam int PADDED = 1 << ST_W;

   always_ff @(posedge clk) begin
      if (wr_en && (int'(wr_addr) < DEPTH)) begin
         mem[wr_addr] <= wr_data;
      end
   end

   generate
      if (PADDED == DEPTH) begin : g_full
         assign rd_data = mem[rd_addr];
      end else begin : g_partial
         always_comb begin
            rd_data = '0;
            for (int i = 0; i < DEPTH; i++) begin
               if (int'(rd_addr) == i) rd_data = mem[i];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/tcm_counter_bank.sv
module tcm_counter_bank #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             inc_all,
   input  logic [2:0]       dec_vec,
   input  logic [2:0]       ld_vec,
   input  logic [CNT_W-1:0] ld_val,
   output logic [CNT_W-1:0] cnt [3],
   output logic [2:0]       is_zero,
   output logic [2:0]       is_max
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   for (genvar g = 0; g < tcm_pkg::NUM_CNT; g++) begin : g_lane
      logic [CNT_W-1:0] val_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            val_q <= '0;
         end else if (ld_vec[g]) begin
            val_q <= ld_val;
         end else if (inc_all) begin
            val_q <= val_q + 1'b1;
         end else if (dec_vec[g]) begin
            val_q <= val_q - 1'b1;
         end
      end

      assign cnt[g]     = val_q;
      assign is_zero[g] = (val_q == '0);
      assign is_max[g]  = (val_q == CNT_MAX);

      // R2: a decrement is only ever requested on a nonzero lane
      a_r2_dec_nonzero: assert property (@(posedge clk) disable iff (rst)
         dec_vec[g] |-> (val_q != '0));
      // R7: an increment is only ever requested below the limit
      a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
         inc_all |-> (val_q != CNT_MAX));
   end

   // R2: at most one lane decrements, never together with an increment
   a_r2_single_dec: assert property (@(posedge clk) disable iff (rst)
      $onehot0(dec_vec) && !(inc_all && (dec_vec != 3'b000)));

endmodule

// File: rtl/tcm_seq.sv
module tcm_seq #(
   parameter int DEPTH  = 12,
   parameter int ST_W   = 4,
   parameter int WORD_W = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [WORD_W-1:0] word,
   input  logic [2:0]        is_zero,
   input  logic [2:0]        is_max,
   output logic [ST_W-1:0]   state,
   output logic              busy,
   output logic              done,
   output logic              err_ovf,
   output logic              err_range,
   output logic              inc_all,
   output logic [2:0]        dec_vec
);
   import tcm_pkg::*;

   tcm_op_e           op;
   logic [ST_W-1:0]   tgt;
   logic [ST_W:0]     nxt;
   logic              sel_zero;
   logic              ovf_hit;
   logic              rng_hit;
   logic              commit;

   assign op  = tcm_op_e'(word[1:0]);
   assign tgt = word[WORD_W-1:2];

   always_comb begin
      sel_zero = 1'b0;
      case (op)
         OP_TST0: sel_zero = is_zero[0];
         OP_TST1: sel_zero = is_zero[1];
         OP_TST2: sel_zero = is_zero[2];
         default: sel_zero = 1'b0;
      endcase
   end

   assign nxt     = (op != OP_BUMPALL && sel_zero) ? ({1'b0, tgt} + 1'b1) : {1'b0, tgt};
   assign ovf_hit = busy && (op == OP_BUMPALL) && (is_max != 3'b000);
   assign rng_hit = busy && (int'(nxt) >= DEPTH);
   assign commit  = busy && !ovf_hit && !rng_hit;

   always_comb begin
      inc_all = 1'b0;
      dec_vec = 3'b000;
      if (commit) begin
         if (op == OP_BUMPALL) begin
            inc_all = 1'b1;
         end else if (!sel_zero) begin
            dec_vec[op] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= '0;
         busy      <= 1'b0;
         done      <= 1'b0;
         err_ovf   <= 1'b0;
         err_range <= 1'b0;
      end else if (busy) begin
         if (ovf_hit)   err_ovf   <= 1'b1;
         if (rng_hit)   err_range <= 1'b1;
         if (!commit) begin
            busy <= 1'b0;
         end else begin
            state <= nxt[ST_W-1:0];
            if (nxt == '0) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end else if (start && !err_ovf && !err_range) begin
         state <= ST_W'(1);
         busy  <= 1'b1;
         done  <= 1'b0;
      end
   end

   // R5: running and halted are never reported together
   a_r5_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
      !(busy && done));
   // R5: a running engine never sits in the halt state
   a_r5_run_not_halt: assert property (@(posedge clk) disable iff (rst)
      busy |-> (state != '0));
   // R7: overflow flag is sticky
   a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
      err_ovf |=> err_ovf);
   // R8: range flag is sticky
   a_r8_range_sticky: assert property (@(posedge clk) disable iff (rst)
      err_range |=> err_range);
   // R9: no run starts while an error is pending
   a_r9_err_blocks: assert property (@(posedge clk) disable iff (rst)
      (!busy && (err_ovf || err_range)) |=> !busy);
   // R8: the state register always indexes inside the table
   a_r8_state_inside: assert property (@(posedge clk) disable iff (rst)
      int'(state) < DEPTH);

endmodule

// File: rtl/tcm_engine.sv
module tcm_engine #(
   parameter int CNT_W  = 8,
   parameter int DEPTH  = 12,
   localparam int ST_W   = (DEPTH > 2) ? $clog2(DEPTH) : 1,
   localparam int WORD_W = ST_W + 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              prog_we,
   input  logic [ST_W-1:0]   prog_addr,
   input  logic [WORD_W-1:0] prog_data,
   input  logic              ld_en,
   input  logic [1:0]        ld_sel,
   input  logic [CNT_W-1:0]  ld_val,
   input  logic              start,
   output logic              busy,
   output logic              done,
   output logic              err_ovf,
   output logic              err_range,
   output logic [CNT_W-1:0]  cnt0,
   output logic [CNT_W-1:0]  cnt1,
   output logic [CNT_W-1:0]  cnt2
);

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("tcm_engine: CNT_W must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("tcm_engine: DEPTH must hold a halt state and a start state");
      end
   endgenerate

   logic [ST_W-1:0]   state;
   logic [WORD_W-1:0] word;
   logic [CNT_W-1:0]  cnt [3];
   logic [2:0]        is_zero;
   logic [2:0]        is_max;
   logic              inc_all;
   logic [2:0]        dec_vec;
   logic [2:0]        ld_vec;
   logic              idle;

   assign idle = !busy;

   always_comb begin
      ld_vec = 3'b000;
      if (ld_en && idle && ld_sel != 2'd3) ld_vec[ld_sel] = 1'b1;
   end

   tcm_prog_mem #(.DEPTH(DEPTH), .ST_W(ST_W), .WORD_W(WORD_W)) u_mem (
      .clk     (clk),
      .wr_en   (prog_we && idle),
      .wr_addr (prog_addr),
      .wr_data (prog_data),
      .rd_addr (state),
      .rd_data (word)
   );

   tcm_counter_bank #(.CNT_W(CNT_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .inc_all (inc_all),
      .dec_vec (dec_vec),
      .ld_vec  (ld_vec),
      .ld_val  (ld_val),
      .cnt     (cnt),
      .is_zero (is_zero),
      .is_max  (is_max)
   );

   tcm_seq #(.DEPTH(DEPTH), .ST_W(ST_W), .WORD_W(WORD_W)) u_seq (
      .clk       (clk),
      .rst       (rst),
      .start     (start),
      .word      (word),
      .is_zero   (is_zero),
      .is_max    (is_max),
      .state     (state),
      .busy      (busy),
      .done      (done),
      .err_ovf   (err_ovf),
      .err_range (err_range),
      .inc_all   (inc_all),
      .dec_vec   (dec_vec)
   );

   assign cnt0 = cnt[0];
   assign cnt1 = cnt[1];
   assign cnt2 = cnt[2];

   // R5: after halting the counters hold still until a load or a new run
   a_r5_done_freeze: assert property (@(posedge clk) disable iff (rst)
      (done && !ld_en && !start) |=> ($stable(cnt0) && $stable(cnt1) && $stable(cnt2)));
   // R4: a committed bump raises every counter by exactly one
   a_r4_bump_all: assert property (@(posedge clk) disable iff (rst)
      (busy && word[1:0] == 2'd3 && is_max == 3'b000 && !err_range && int'(word[WORD_W-1:2]) < DEPTH)
      |=> (cnt0 == $past(cnt0) + 1'b1 && cnt1 == $past(cnt1) + 1'b1 && cnt2 == $past(cnt2) + 1'b1));
   // R3: a test on a zero counter leaves all counters unchanged
   a_r3_zero_keeps: assert property (@(posedge clk) disable iff (rst)
      (busy && word[1:0] != 2'd3 && is_zero[word[1:0]])
      |=> ($stable(cnt0) && $stable(cnt1) && $stable(cnt2)));
   // R6: loads issued while running do not reach the counters
   a_r6_busy_no_load: assert property (@(posedge clk) disable iff (rst)
      (busy && word[1:0] != 2'd3 && is_zero[word[1:0]] && ld_en) |=> $stable(cnt0));

endmodule

// File: tb/tcm_engine_test.sv
module tcm_engine_test;

   localparam int CNT_W  = 8;
   localparam int DEPTH  = 12;
   localparam int ST_W   = 4;
   localparam int WORD_W = 6;
   localparam int CMAX   = (1 << CNT_W) - 1;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              prog_we = 1'b0;
   logic [ST_W-1:0]   prog_addr = '0;
   logic [WORD_W-1:0] prog_data = '0;
   logic              ld_en = 1'b0;
   logic [1:0]        ld_sel = '0;
   logic [CNT_W-1:0]  ld_val = '0;
   logic              start = 1'b0;
   logic              busy, done, err_ovf, err_range;
   logic [CNT_W-1:0]  cnt0, cnt1, cnt2;

   int checks = 0;
   int errors = 0;
   int prog [DEPTH];
   int m_c [3];
   int m_steps;
   bit m_done, m_ovf, m_rng;
   int steps;
   bit hung = 0;

   always #2.5 clk = ~clk;

   tcm_engine #(.CNT_W(CNT_W), .DEPTH(DEPTH)) uut (
      .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
      .prog_data(prog_data), .ld_en(ld_en), .ld_sel(ld_sel), .ld_val(ld_val),
      .start(start), .busy(busy), .done(done), .err_ovf(err_ovf),
      .err_range(err_range), .cnt0(cnt0), .cnt1(cnt1), .cnt2(cnt2)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic write_prog();
      for (int i = 0; i < DEPTH; i++) begin
         @(negedge clk);
         prog_we = 1'b1; prog_addr = ST_W'(i); prog_data = WORD_W'(prog[i]);
      end
      @(negedge clk);
      prog_we = 1'b0;
   endtask

   task automatic load(input int sel, input int val);
      @(negedge clk);
      ld_en = 1'b1; ld_sel = 2'(sel); ld_val = CNT_W'(val);
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic load3(input int a, input int b, input int c);
      load(0, a); load(1, b); load(2, c);
   endtask

   // Step-by-step model of the instruction semantics (R1-style decode in arithmetic)
   task automatic model(input int a, input int b, input int c);
      int pc, w, op, j, nx;
      bit zero;
      m_c[0] = a; m_c[1] = b; m_c[2] = c;
      m_steps = 0; m_done = 0; m_ovf = 0; m_rng = 0;
      pc = 1;
      while (!m_done && !m_ovf && !m_rng && m_steps < 5000) begin
         m_steps++;
         w = prog[pc]; op = w % 4; j = w / 4;
         zero = (op != 3) && (m_c[op] == 0);
         nx = zero ? j + 1 : j;
         if (op == 3 && (m_c[0] == CMAX || m_c[1] == CMAX || m_c[2] == CMAX)) m_ovf = 1;
         if (nx >= DEPTH) m_rng = 1;
         if (!m_ovf && !m_rng) begin
            if (op == 3) begin
               for (int k = 0; k < 3; k++) m_c[k]++;
            end else if (!zero) begin
               m_c[op]--;
            end
            pc = nx;
            if (pc == 0) m_done = 1;
         end
      end
   endtask

   // mode 1: re-pulse start mid-run; mode 2: load counter 0 mid-run
   task automatic run(input int mode);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      steps = 0;
      while (busy && steps < 5000) begin
         steps++;
         if (steps == 3 && mode == 1) start = 1'b1;
         else if (steps == 3 && mode == 2) begin ld_en = 1'b1; ld_sel = 2'd0; ld_val = 8'd99; end
         else begin start = 1'b0; ld_en = 1'b0; end
         @(negedge clk);
      end
      start = 1'b0; ld_en = 1'b0;
   endtask

   task automatic compare(input string req);
      check({req, " cnt0"}, int'(cnt0), m_c[0]);
      check({req, " cnt1"}, int'(cnt1), m_c[1]);
      check({req, " cnt2"}, int'(cnt2), m_c[2]);
      check({req, " done"}, int'(done), int'(m_done));
      check({req, " err_ovf"}, int'(err_ovf), int'(m_ovf));
      check({req, " err_range"}, int'(err_range), int'(m_rng));
      check({req, " steps"}, steps, m_steps);
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      @(negedge clk); @(negedge clk); rst = 1'b0;
   endtask

   initial begin
      #400000;
      hung = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      // R10: reset state
      check("R10 cnt0", int'(cnt0), 0);
      check("R10 cnt1", int'(cnt1), 0);
      check("R10 cnt2", int'(cnt2), 0);
      check("R10 busy", int'(busy), 0);
      check("R10 done", int'(done), 0);
      check("R10 errors", int'(err_ovf) + int'(err_range), 0);

      // R11: loads, including the ignored select value 3
      load3(7, 8, 9); load(3, 55);
      check("R11 cnt0", int'(cnt0), 7);
      check("R11 cnt1", int'(cnt1), 8);
      check("R11 cnt2", int'(cnt2), 9);

      // Addition-style loop: exercises R1 R2 R3 R4 R5
      for (int i = 0; i < DEPTH; i++) prog[i] = 0;
      prog[1] = 4*2 + 1; prog[2] = 4*4 + 3; prog[4] = 4*5 + 1;
      prog[5] = 4*1 + 2; prog[3] = 4*6 + 3; prog[6] = 4*0 + 1;
      write_prog();
      for (int a = 0; a < 6; a++)
         for (int b = 0; b < 6; b++)
            for (int c = 0; c < 4; c += 3) begin
               load3(a, b, c);
               model(a, b, c);
               run(0);
               compare("R2/R3/R4/R5 sweep");
            end

      // R5: counters frozen after done
      repeat (4) @(negedge clk);
      check("R5 frozen cnt0", int'(cnt0), m_c[0]);

      // R6: start and load during a run are ignored
      load3(3, 5, 1); model(3, 5, 1); run(1);
      compare("R6 start-busy");
      load3(3, 5, 1); model(3, 5, 1); run(2);
      compare("R6 load-busy");

      // R10: reset keeps the table
      do_reset();
      check("R10 post cnt0", int'(cnt0), 0);
      check("R10 post done", int'(done), 0);
      load3(2, 4, 0); model(2, 4, 0); run(0);
      compare("R10 table kept");

      // R7: overflow from a self-looping bump near the limit
      for (int i = 0; i < DEPTH; i++) prog[i] = 0;
      prog[1] = 4*1 + 3;
      write_prog();
      for (int k = 0; k < 5; k++) begin
         do_reset();
         load3(CMAX - k, 10, k);
         model(CMAX - k, 10, k);
         run(0);
         compare("R7 overflow");
      end
      // R9: start ignored while in error
      @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
      check("R9 busy", int'(busy), 0);
      check("R9 err_ovf kept", int'(err_ovf), 1);
      check("R9 cnt0 unchanged", int'(cnt0), CMAX);

      // R8: target j+1 past the table on a zero counter, and direct target past it
      for (int i = 0; i < DEPTH; i++) prog[i] = 0;
      prog[1] = 4*11 + 2; prog[11] = 4*0 + 3;
      write_prog();
      for (int c = 0; c < 3; c++)
         for (int a = 0; a < 3; a++) begin
            do_reset();
            load3(a, 1, c); model(a, 1, c); run(0);
            compare("R8 j+1 range");
         end
      prog[1] = 4*13 + 3;
      write_prog();
      do_reset();
      load3(4, 5, 6); model(4, 5, 6); run(0);
      compare("R8 direct range");

      if (!hung) begin
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule